// File: doc/BRIEF.md
# NAND ECC Status Classifier

This block sits beside a serial NAND controller and decides what a page read produced once the device has finished its internal array transfer. After a start pulse it reads the device status register again and again through a small register-read port until the busy bit drops. It then reduces the error-correction field reported by the device to one of three verdicts. OK means the data is clean or was corrected. REFRESH means the data was corrected, but the page should be rewritten soon. ERROR means the data could not be corrected.

Different device families report their correction outcome in different bit fields and with different thresholds. A 3-bit mode input, sampled at start, selects one of seven encodings. Two of them assemble a 4-bit code from two separate registers. A failed register read, or running out of poll attempts, ends the operation early. The caller sees a one-cycle `done` pulse and a 2-bit verdict that stays put until the next operation finishes.

Top module: `nand_ecc_classifier`

## Requirements
- R1: While reset is asserted and directly after it, `done` is 0, `rd_req` is 0 and `result` is 0. Verdict encoding: 0 = OK, 1 = REFRESH, 2 = ERROR.
- R2: After `start`, the block reads register address 0xC0 and repeats the read while bit 0 of the returned byte is 1. Between a busy response and the next read, `rd_req` stays low for exactly GAP_CYCLES+1 cycles. When the operation finishes, `done` is high for exactly one cycle.
- R3: Mode 0 takes code = bits [5:4] of 0xC0. Codes 0 and 1 give OK, code 2 gives ERROR and code 3 gives REFRESH.
- R4: Mode 1 takes code = bits [5:4] of 0xC0. Code 0 gives OK, code 1 gives REFRESH, and codes 2 and 3 give ERROR.
- R5: Modes 2 and 3 read 0xC0 first and then 0xF0 on every poll. The 4-bit code is {0xC0[5:4], 0xF0[5:4]}. In mode 2, codes 0 to 6 give OK, code 7 gives REFRESH and every other code gives ERROR.
- R6: Mode 3 follows mode 2, except that codes 12 to 15 also give REFRESH.
- R7: Mode 4 takes code = bits [5:2] of 0xC0. Codes 0 to 6 give OK, codes 7 and 12 give REFRESH, and every other code gives ERROR.
- R8: Mode 5 takes code = bits [6:4] of 0xC0. Codes 0 to 3 give OK, code 4 gives REFRESH, and codes 5 to 7 give ERROR.
- R9: Mode 6 takes code = bits [6:4] of 0xC0. Codes 0, 1 and 3 give OK, code 5 gives REFRESH, and every other code gives ERROR.
- R10: A response with `rd_fail` high ends the operation on the next cycle with ERROR, and no further read is issued.
- R11: After MAX_POLLS reads of 0xC0 that all return busy, the operation ends, and the verdict comes from the last status byte read.
- R12: Mode 7 gives ERROR for any status.
- R13: `result` changes only in the cycle in which `done` is high. A `start` that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| mode | input | 3 | Encoding select, sampled at start |
| rd_req | output | 1 | Register read request, held until acknowledged |
| rd_addr | output | 8 | Register address of the pending read |
| rd_ack | input | 1 | One-cycle response strobe |
| rd_data | input | 8 | Register byte, valid with `rd_ack` |
| rd_fail | input | 1 | Read failed, valid with `rd_ack` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Verdict: 0 OK, 1 REFRESH, 2 ERROR |

## Verification
A poll sequencer that loses its place shows up at the read port within one request. It might skip the second register in the dual-register modes, read again after a failure, or read more often than the poll limit allows. The bench counts and logs those requests per operation. A wrong field slice or threshold appears only in the verdict presented with `done`, so every code value of every mode is swept through a full operation. A sequencer that fails to return to idle shows up as a missing or repeated `done` pulse within a few cycles of the final response.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   typedef enum logic [1:0] {
      ECC_OK      = 2'd0,
      ECC_REFRESH = 2'd1,
      ECC_ERROR   = 2'd2
   } ecc_verdict_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RD_MAIN,
      SQ_RD_AUX,
      SQ_CHECK,
      SQ_WAIT
   } seq_state_e;

   localparam logic [7:0] ADDR_STATUS = 8'hC0;
   localparam logic [7:0] ADDR_AUX    = 8'hF0;

endpackage

// File: rtl/nand_ecc_decode.sv
module nand_ecc_decode
   import nand_ecc_pkg::*;
(
   input  logic [2:0]   mode,
   input  logic [7:0]   st_main,
   input  logic [7:0]   st_aux,
   output ecc_verdict_e verdict
);

   logic [1:0] f_pair;
   logic [3:0] f_dual;
   logic [3:0] f_wide;
   logic [2:0] f_tri;
   logic       unused_bits;

   assign f_pair      = st_main[5:4];
   assign f_dual      = {st_main[5:4], st_aux[5:4]};
   assign f_wide      = st_main[5:2];
   assign f_tri       = st_main[6:4];
   assign unused_bits = ^{st_main[7], st_main[1:0], st_aux[7:6], st_aux[3:0]};

   always_comb begin
      verdict = ECC_ERROR;
      case (mode)
         3'd0: begin
            if (f_pair == 2'd2)      verdict = ECC_ERROR;
            else if (f_pair == 2'd3) verdict = ECC_REFRESH;
            else                     verdict = ECC_OK;
         end
         3'd1: begin
            if (f_pair == 2'd0)      verdict = ECC_OK;
            else if (f_pair == 2'd1) verdict = ECC_REFRESH;
            else                     verdict = ECC_ERROR;
         end
         3'd2: begin
            if (f_dual < 4'd7)       verdict = ECC_OK;
            else if (f_dual == 4'd7) verdict = ECC_REFRESH;
            else                     verdict = ECC_ERROR;
         end
         3'd3: begin
            if (f_dual < 4'd7)                           verdict = ECC_OK;
            else if (f_dual == 4'd7 || f_dual >= 4'd12)  verdict = ECC_REFRESH;
            else                                         verdict = ECC_ERROR;
         end
         3'd4: begin
            if (f_wide < 4'd7)                           verdict = ECC_OK;
            else if (f_wide == 4'd7 || f_wide == 4'd12)  verdict = ECC_REFRESH;
            else                                         verdict = ECC_ERROR;
         end
         3'd5: begin
            if (f_tri < 3'd4)        verdict = ECC_OK;
            else if (f_tri == 3'd4)  verdict = ECC_REFRESH;
            else                     verdict = ECC_ERROR;
         end
         3'd6: begin
            if (f_tri == 3'd0 || f_tri == 3'd1 || f_tri == 3'd3) verdict = ECC_OK;
            else if (f_tri == 3'd5)                               verdict = ECC_REFRESH;
            else                                                  verdict = ECC_ERROR;
         end
         default: verdict = ECC_ERROR;
      endcase
   end

endmodule

// File: rtl/nand_ecc_gap_timer.sv
module nand_ecc_gap_timer #(
   parameter int unsigned GAP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic idle
);

   generate
      if (GAP_CYCLES == 0) begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, arm};
         assign idle      = 1'b1;
      end else begin : g_count
         localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (arm)           cnt <= CW'(GAP_CYCLES - 1);
            else if (cnt != '0)     cnt <= cnt - 1'b1;
         end

         assign idle = (cnt == '0);

         // R2
         arm_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arm |-> idle);
      end
   endgenerate

endmodule

// File: rtl/nand_ecc_poll_seq.sv
module nand_ecc_poll_seq
   import nand_ecc_pkg::*;
#(
   parameter int unsigned MAX_POLLS  = 1000000,
   parameter int unsigned GAP_CYCLES = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [2:0]   mode,
   output logic         rd_req,
   output logic [7:0]   rd_addr,
   input  logic         rd_ack,
   input  logic [7:0]   rd_data,
   input  logic         rd_fail,
   output logic         gap_arm,
   input  logic         gap_idle,
   input  ecc_verdict_e verdict,
   output logic [2:0]   mode_q,
   output logic [7:0]   st_main,
   output logic [7:0]   st_aux,
   output logic         done,
   output ecc_verdict_e result
);

   localparam int  PCW     = $clog2(MAX_POLLS + 1);
   localparam bit  HAS_GAP = (GAP_CYCLES != 0);

   generate
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("MAX_POLLS must be at least 1");
      end
   endgenerate

   seq_state_e   state;
   logic [PCW-1:0] poll_cnt;
   logic         dual;
   logic         last_poll;
   logic         busy_bit;

   assign dual      = (mode_q == 3'd2) || (mode_q == 3'd3);
   assign last_poll = (poll_cnt == PCW'(MAX_POLLS - 1));
   assign busy_bit  = st_main[0];
   assign rd_req    = (state == SQ_RD_MAIN) || (state == SQ_RD_AUX);
   assign rd_addr   = (state == SQ_RD_AUX) ? ADDR_AUX : ADDR_STATUS;
   assign gap_arm   = HAS_GAP && (state == SQ_CHECK) && busy_bit && !last_poll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         poll_cnt <= '0;
         mode_q   <= '0;
         st_main  <= '0;
         st_aux   <= '0;
         done     <= 1'b0;
         result   <= ECC_OK;
      end else begin
         done <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  mode_q   <= mode;
                  poll_cnt <= '0;
                  state    <= SQ_RD_MAIN;
               end
            end
            SQ_RD_MAIN: begin
               if (rd_ack) begin
                  if (rd_fail) begin
                     done   <= 1'b1;
                     result <= ECC_ERROR;
                     state  <= SQ_IDLE;
                  end else begin
                     st_main <= rd_data;
                     state   <= dual ? SQ_RD_AUX : SQ_CHECK;
                  end
               end
            end
            SQ_RD_AUX: begin
               if (rd_ack) begin
                  if (rd_fail) begin
                     done   <= 1'b1;
                     result <= ECC_ERROR;
                     state  <= SQ_IDLE;
                  end else begin
                     st_aux <= rd_data;
                     state  <= SQ_CHECK;
                  end
               end
            end
            SQ_CHECK: begin
               poll_cnt <= poll_cnt + 1'b1;
               if (!busy_bit || last_poll) begin
                  done   <= 1'b1;
                  result <= verdict;
                  state  <= SQ_IDLE;
               end else begin
                  state <= HAS_GAP ? SQ_WAIT : SQ_RD_MAIN;
               end
            end
            SQ_WAIT: begin
               if (gap_idle) state <= SQ_RD_MAIN;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   // R10
   fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && rd_fail) |=> (done && result == ECC_ERROR && !rd_req));

   // R11
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt <= PCW'(MAX_POLLS));

   // R13
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

endmodule

// File: rtl/nand_ecc_classifier.sv
module nand_ecc_classifier
   import nand_ecc_pkg::*;
#(
   parameter int unsigned MAX_POLLS  = 1000000,
   parameter int unsigned GAP_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] mode,
   output logic       rd_req,
   output logic [7:0] rd_addr,
   input  logic       rd_ack,
   input  logic [7:0] rd_data,
   input  logic       rd_fail,
   output logic       done,
   output logic [1:0] result
);

   ecc_verdict_e verdict;
   ecc_verdict_e result_e;
   logic [2:0]   mode_q;
   logic [7:0]   st_main;
   logic [7:0]   st_aux;
   logic         gap_arm;
   logic         gap_idle;

   nand_ecc_poll_seq #(
      .MAX_POLLS  (MAX_POLLS),
      .GAP_CYCLES (GAP_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode     (mode),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .rd_ack   (rd_ack),
      .rd_data  (rd_data),
      .rd_fail  (rd_fail),
      .gap_arm  (gap_arm),
      .gap_idle (gap_idle),
      .verdict  (verdict),
      .mode_q   (mode_q),
      .st_main  (st_main),
      .st_aux   (st_aux),
      .done     (done),
      .result   (result_e)
   );

   nand_ecc_gap_timer #(
      .GAP_CYCLES (GAP_CYCLES)
   ) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (gap_arm),
      .idle  (gap_idle)
   );

   nand_ecc_decode u_dec (
      .mode    (mode_q),
      .st_main (st_main),
      .st_aux  (st_aux),
      .verdict (verdict)
   );

   assign result = result_e;

endmodule

// File: tb/nand_ecc_classifier_bench.sv
module nand_ecc_classifier_bench;

   localparam int MAX_B = 5;
   localparam int GAP_B = 3;

   logic       clk;
   logic       rst_n;
   logic       start;
   logic [2:0] mode;
   logic       rd_req;
   logic [7:0] rd_addr;
   logic       rd_ack;
   logic [7:0] rd_data;
   logic       rd_fail;
   logic       done;
   logic [1:0] result;

   logic [7:0] c0_seq [8];
   logic [7:0] f0_val;
   logic [7:0] addr_log [4];
   int fail_at;
   int n_reads;
   int n_c0;
   int done_cnt;
   int last_gap;
   int low_cnt;
   bit seen_ack;
   logic [1:0] got_res;
   int checks;
   int fails;

   nand_ecc_classifier #(
      .MAX_POLLS  (MAX_B),
      .GAP_CYCLES (GAP_B)
   ) u_nand_ecc_classifier (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode    (mode),
      .rd_req  (rd_req),
      .rd_addr (rd_addr),
      .rd_ack  (rd_ack),
      .rd_data (rd_data),
      .rd_fail (rd_fail),
      .done    (done),
      .result  (result)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   // device model: answers one cycle after a request is seen
   initial begin
      rd_ack  = 1'b0;
      rd_data = 8'h00;
      rd_fail = 1'b0;
      forever begin
         @(posedge clk);
         if (rd_req && !rd_ack) begin
            rd_ack <= 1'b1;
            if (rd_addr == 8'hC0) begin
               rd_data <= c0_seq[(n_c0 < 8) ? n_c0 : 7];
               n_c0    <= n_c0 + 1;
            end else begin
               rd_data <= f0_val;
            end
            if (n_reads < 4) addr_log[n_reads] <= rd_addr;
            rd_fail <= (n_reads == fail_at);
            n_reads <= n_reads + 1;
         end else begin
            rd_ack  <= 1'b0;
            rd_fail <= 1'b0;
         end
      end
   end

   // port monitor
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            done_cnt = done_cnt + 1;
            got_res  = result;
         end
         if (rd_ack) begin
            seen_ack = 1'b1;
            low_cnt  = 0;
         end else if (rd_req && seen_ack) begin
            last_gap = low_cnt;
            seen_ack = 1'b0;
         end else if (!rd_req && seen_ack) begin
            low_cnt = low_cnt + 1;
         end
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic fill_c0(input logic [7:0] v);
      for (int i = 0; i < 8; i++) c0_seq[i] = v;
   endtask

   task automatic run_op(input logic [2:0] m, input int extra_start_at);
      bit finished;
      n_reads  = 0;
      n_c0     = 0;
      done_cnt = 0;
      seen_ack = 1'b0;
      last_gap = -1;
      for (int i = 0; i < 4; i++) addr_log[i] = 8'h00;
      @(negedge clk);
      mode  = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finished = 1'b0;
      for (int cyc = 0; cyc < 500; cyc++) begin
         if (cyc == extra_start_at) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         if (done_cnt > 0) begin
            finished = 1'b1;
            break;
         end
      end
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk(finished, "R2 operation completes", finished, 1);
   endtask

   task automatic test_reset();
      chk(done == 1'b0, "R1 done after reset", done, 0);
      chk(rd_req == 1'b0, "R1 rd_req after reset", rd_req, 0);
      chk(result == 2'd0, "R1 result after reset", result, 0);
   endtask

   task automatic sweep(input logic [2:0] m, input int ncodes, input logic [15:0] okm,
                        input logic [15:0] refm, input string tag);
      for (int c = 0; c < ncodes; c++) begin
         logic [3:0] cv;
         int exp;
         cv = 4'(c);
         f0_val = 8'hC1;
         case (m)
            3'd0, 3'd1: fill_c0(8'hCC | {2'b00, cv[1:0], 4'h0});
            3'd2, 3'd3: begin
               fill_c0(8'h80 | {2'b00, cv[3:2], 4'h0});
               f0_val = 8'hC1 | {2'b00, cv[1:0], 4'h0};
            end
            3'd4:       fill_c0(8'h80 | {2'b00, cv, 2'b00});
            3'd5, 3'd6: fill_c0(8'h80 | {1'b0, cv[2:0], 4'h0});
            default:    fill_c0(8'h00);
         endcase
         exp = okm[c] ? 0 : (refm[c] ? 1 : 2);
         run_op(m, -1);
         chk(got_res == 2'(exp), $sformatf("%s mode %0d code %0d", tag, m, c), got_res, exp);
      end
   endtask

   task automatic test_busy_poll();
      fail_at = -1;
      fill_c0(8'h30);
      c0_seq[0] = 8'h01;
      c0_seq[1] = 8'h01;
      run_op(3'd0, -1);
      chk(n_c0 == 3, "R2 status reads until ready", n_c0, 3);
      chk(got_res == 2'd1, "R2 verdict from ready status", got_res, 1);
      chk(last_gap == GAP_B + 1, "R2 idle cycles between polls", last_gap, GAP_B + 1);
      chk(done_cnt == 1, "R2 single done pulse", done_cnt, 1);
   endtask

   task automatic test_dual_order();
      fail_at = -1;
      fill_c0(8'h10);
      f0_val = 8'h30;
      run_op(3'd2, -1);
      chk(addr_log[0] == 8'hC0, "R5 first read address", addr_log[0], 8'hC0);
      chk(addr_log[1] == 8'hF0, "R5 second read address", addr_log[1], 8'hF0);
      chk(n_reads == 2, "R5 reads per ready poll", n_reads, 2);
      chk(got_res == 2'd1, "R5 code 7 verdict", got_res, 1);
      fill_c0(8'h10);
      c0_seq[0] = 8'h11;
      run_op(3'd3, -1);
      chk(n_reads == 4, "R5 both registers each poll", n_reads, 4);
      chk(addr_log[2] == 8'hC0 && addr_log[3] == 8'hF0, "R5 order on second poll",
          addr_log[3], 8'hF0);
   endtask

   task automatic test_fail();
      fill_c0(8'h00);
      fail_at = 0;
      run_op(3'd0, -1);
      chk(got_res == 2'd2, "R10 failed first read verdict", got_res, 2);
      chk(n_reads == 1, "R10 no read after failure", n_reads, 1);
      f0_val  = 8'h00;
      fail_at = 1;
      run_op(3'd2, -1);
      chk(got_res == 2'd2, "R10 failed aux read verdict", got_res, 2);
      chk(n_reads == 2, "R10 stop after aux failure", n_reads, 2);
      fill_c0(8'h00);
      c0_seq[0] = 8'h01;
      fail_at = 1;
      run_op(3'd0, -1);
      chk(got_res == 2'd2, "R10 failure on later poll", got_res, 2);
      chk(n_reads == 2, "R10 reads before later failure", n_reads, 2);
      fail_at = -1;
   endtask

   task automatic test_timeout();
      fail_at = -1;
      fill_c0(8'h00);
      for (int i = 0; i < 4; i++) c0_seq[i] = 8'h21;
      c0_seq[4] = 8'h11;
      run_op(3'd1, -1);
      chk(n_c0 == MAX_B, "R11 reads capped at limit", n_c0, MAX_B);
      chk(got_res == 2'd1, "R11 last status classified", got_res, 1);
   endtask

   task automatic test_hold_and_ignore();
      fail_at = -1;
      fill_c0(8'h30);
      run_op(3'd0, -1);
      chk(got_res == 2'd1, "R13 setup verdict", got_res, 1);
      repeat (10) @(negedge clk);
      chk(result == 2'd1, "R13 result held while idle", result, 1);
      fill_c0(8'h20);
      c0_seq[0] = 8'h01;
      c0_seq[1] = 8'h01;
      c0_seq[2] = 8'h01;
      run_op(3'd0, 6);
      repeat (40) @(negedge clk);
      chk(done_cnt == 1, "R13 start while running ignored (done)", done_cnt, 1);
      chk(n_c0 == 4, "R13 start while running ignored (reads)", n_c0, 4);
      chk(result == 2'd2, "R13 verdict of running op", result, 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
   end

   initial begin
      checks  = 0;
      fails   = 0;
      fail_at = -1;
      n_reads = 0;
      n_c0    = 0;
      done_cnt = 0;
      seen_ack = 1'b0;
      low_cnt  = 0;
      last_gap = -1;
      got_res  = 2'd0;
      f0_val   = 8'h00;
      fill_c0(8'h00);
      start = 1'b0;
      mode  = 3'd0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      sweep(3'd0, 4,  16'h0003, 16'h0008, "R3");
      sweep(3'd1, 4,  16'h0001, 16'h0002, "R4");
      sweep(3'd2, 16, 16'h007F, 16'h0080, "R5");
      sweep(3'd3, 16, 16'h007F, 16'hF080, "R6");
      sweep(3'd4, 16, 16'h007F, 16'h1080, "R7");
      sweep(3'd5, 8,  16'h000F, 16'h0010, "R8");
      sweep(3'd6, 8,  16'h000B, 16'h0020, "R9");
      sweep(3'd7, 1,  16'h0000, 16'h0000, "R12");
      test_busy_poll();
      test_dual_order();
      test_fail();
      test_timeout();
      test_hold_and_ignore();
      report();
      $finish;
   end

endmodule